// File: doc/BRIEF.md
# Pulse-Gap Tag Programming Modulator

This block programs a passive low-frequency tag by switching the reader field on and off. A write is started with a one-cycle `start` pulse, and the block captures a 64-bit data word and a 16-bit check value at that moment. It first holds the field on for a charge interval, and then sends a fixed 112-bit command frame. Each bit is a field-off gap followed by a field-on interval. After the frame it holds the field on for a programming interval, then releases the field and pulses `done`.

A one bit uses an equal gap and on-time. A zero bit uses a short gap and a long on-time. Both bit kinds last the same total time. All intervals are integer counts of a microsecond tick, which a prescaler derives from the clock. If the supplied check value is zero, the block computes a CRC over the data and sends that CRC in its place.

Top module: `pulse_gap_writer`

## Requirements
- R1: After reset, and whenever no write is in progress, `fieldOn`, `busy` and `done` are all low.
- R2: When `start` is sampled high while idle, `fieldOn` and `busy` go high on that clock edge. The field then stays on for exactly CHARGE_US ticks before the first gap. One tick is CLKS_PER_US clock cycles.
- R3: A one bit is sent as ONE_OFF_US ticks with the field off, followed by ONE_ON_US ticks with the field on.
- R4: A zero bit is sent as ZERO_OFF_US ticks with the field off, followed by ZERO_ON_US ticks with the field on.
- R5: Within each byte of the frame, bit 0 is sent first and bit 7 is sent last.
- R6: The 14 frame bytes are sent in this order: 0xBB, 0xEB, then data bytes 0 to 7 (byte k is dataWord[8k+7:8k]), then check low byte, check high byte, 0x00 and 0x03.
- R7: A nonzero `crcIn` is sent unchanged as the check value, even if it does not match the data.
- R8: A zero `crcIn` is replaced by a reflected CRC-16 computed over the 64 data bits. The CRC uses polynomial 0x8408 and initial value 0, and it processes dataWord[0] first through dataWord[63] last.
- R9: After the on-time of the last bit, the field stays on for another HOLD_US ticks and then goes off.
- R10: `busy` stays high from the edge that accepts `start` until the hold ends. On the edge where `busy` falls, `done` goes high for exactly one cycle.
- R11: A `start` pulse, or a change of `dataWord` or `crcIn`, during a write has no effect on the field waveform or on when that write ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a write; sampled only while idle |
| dataWord | input | 64 | Data to program, captured at start |
| crcIn | input | 16 | Check value to send; zero selects the computed CRC |
| fieldOn | output | 1 | Reader field enable, active high |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse when a write finishes |

## Verification
The hardest condition to reach from the ports is a second `start` arriving while a write is in progress, together with changed data and check inputs. The stimulus pulses `start` in the middle of the gap of bit 40 and inverts both data inputs at the same time. The bench then decodes the whole remaining waveform. It also checks that the ending cycle and the decoded bytes still match the original request.

The bench recovers every bit only from the lengths of the field-off and field-on runs. This means a gap or on-time that is off by a single cycle shows up as a timing failure. The last bit's on-time is merged with the hold interval, so the bench checks that final run against the sum of the two.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int FRAME_BITS = 112;
  localparam logic [7:0] KEY_BYTE   = 8'hBB;
  localparam logic [7:0] PASS_BYTE  = 8'hEB;
  localparam logic [7:0] TRAIL_LO   = 8'h00;
  localparam logic [7:0] TRAIL_HI   = 8'h03;

  typedef struct packed {
    logic load;     // capture inputs and build the frame
    logic advance;  // move to the next frame bit
  } pgwStrobe_t;

  // one byte step of the reflected CRC-16, table-free form
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] t;
    t = b ^ c[7:0];
    t = t ^ (t << 4);
    return (c >> 8) ^ {t, 8'h00} ^ {5'h00, t, 3'h0} ^ {12'h000, t[7:4]};
  endfunction

  function automatic logic [15:0] crcOfWord(input logic [63:0] w);
    logic [15:0] c;
    c = 16'h0000;
    for (int k = 0; k < 8; k++) c = crcStep(c, w[8*k +: 8]);
    return c;
  endfunction
endpackage

// File: rtl/pgw_prescaler.sv
module pgw_prescaler #(
  parameter int CLKS_PER_US = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic tick
);
  localparam int PW = $clog2(CLKS_PER_US + 1);
  logic [PW-1:0] preCnt;

  assign tick = (preCnt == PW'(CLKS_PER_US - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (clear || tick) preCnt <= '0;
    else                 preCnt <= preCnt + PW'(1);
  end
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pgwStrobe_t  strobe,
  input  logic [63:0] dataWord,
  input  logic [15:0] crcIn,
  output logic        curBit,
  output logic        nextBit,
  output logic        lastBit
);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] frameReg;
  logic [BW-1:0]         bitsLeft;
  logic [15:0]           crcSel;

  assign crcSel  = (crcIn == 16'h0000) ? crcOfWord(dataWord) : crcIn;
  assign curBit  = frameReg[0];
  assign nextBit = frameReg[1];
  assign lastBit = (bitsLeft == BW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      frameReg <= {TRAIL_HI, TRAIL_LO, crcSel, dataWord, PASS_BYTE, KEY_BYTE};
      bitsLeft <= BW'(FRAME_BITS);
    end else if (strobe.advance) begin
      frameReg <= frameReg >> 1;
      bitsLeft <= bitsLeft - BW'(1);
    end
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int CHARGE_US   = 50000,
  parameter int HOLD_US     = 50000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ONE_ON_US   = 1000,
  parameter int ZERO_OFF_US = 300,
  parameter int ZERO_ON_US  = 1700,
  parameter int CW          = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tick,
  input  logic       curBit,
  input  logic       nextBit,
  input  logic       lastBit,
  output pgwStrobe_t strobe,
  output logic       fieldOn,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {S_IDLE, S_CHARGE, S_GAP, S_ON, S_HOLD} phase_t;

  phase_t        phase;
  logic [CW-1:0] ticksLeft;
  logic          phaseEnd;

  assign phaseEnd = tick && (ticksLeft == '0);
  assign fieldOn  = (phase == S_CHARGE) || (phase == S_ON) || (phase == S_HOLD);
  assign busy     = (phase != S_IDLE);

  always_comb begin
    strobe.load    = (phase == S_IDLE) && start;
    strobe.advance = (phase == S_ON) && phaseEnd && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= S_IDLE;
      ticksLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        S_IDLE: if (start) begin
          phase     <= S_CHARGE;
          ticksLeft <= CW'(CHARGE_US - 1);
        end
        S_CHARGE: if (phaseEnd) begin
          phase     <= S_GAP;
          ticksLeft <= curBit ? CW'(ONE_OFF_US - 1) : CW'(ZERO_OFF_US - 1);
        end else if (tick) ticksLeft <= ticksLeft - CW'(1);
        S_GAP: if (phaseEnd) begin
          phase     <= S_ON;
          ticksLeft <= curBit ? CW'(ONE_ON_US - 1) : CW'(ZERO_ON_US - 1);
        end else if (tick) ticksLeft <= ticksLeft - CW'(1);
        S_ON: if (phaseEnd) begin
          if (lastBit) begin
            phase     <= S_HOLD;
            ticksLeft <= CW'(HOLD_US - 1);
          end else begin
            phase     <= S_GAP;
            ticksLeft <= nextBit ? CW'(ONE_OFF_US - 1) : CW'(ZERO_OFF_US - 1);
          end
        end else if (tick) ticksLeft <= ticksLeft - CW'(1);
        S_HOLD: if (phaseEnd) begin
          phase <= S_IDLE;
          done  <= 1'b1;
        end else if (tick) ticksLeft <= ticksLeft - CW'(1);
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_gap_writer.sv
module pulse_gap_writer
  import pgw_pkg::*;
#(
  parameter int CLKS_PER_US = 48,
  parameter int CHARGE_US   = 50000,
  parameter int HOLD_US     = 50000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ONE_ON_US   = 1000,
  parameter int ZERO_OFF_US = 300,
  parameter int ZERO_ON_US  = 1700
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] dataWord,
  input  logic [15:0] crcIn,
  output logic        fieldOn,
  output logic        busy,
  output logic        done
);
  localparam int MAX_A = (CHARGE_US > HOLD_US) ? CHARGE_US : HOLD_US;
  localparam int MAX_B = (ONE_OFF_US > ONE_ON_US) ? ONE_OFF_US : ONE_ON_US;
  localparam int MAX_C = (ZERO_OFF_US > ZERO_ON_US) ? ZERO_OFF_US : ZERO_ON_US;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_D > MAX_C) ? MAX_D : MAX_C;
  localparam int CW    = $clog2(MAX_T + 1);

  pgwStrobe_t strobe;
  logic tick, curBit, nextBit, lastBit;

  pgw_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
    .clk(clk), .rstN(rstN), .clear(strobe.load), .tick(tick)
  );

  pgw_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWord(dataWord), .crcIn(crcIn),
    .curBit(curBit), .nextBit(nextBit), .lastBit(lastBit)
  );

  pgw_ctrl #(
    .CHARGE_US(CHARGE_US), .HOLD_US(HOLD_US),
    .ONE_OFF_US(ONE_OFF_US), .ONE_ON_US(ONE_ON_US),
    .ZERO_OFF_US(ZERO_OFF_US), .ZERO_ON_US(ZERO_ON_US), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tick(tick),
    .curBit(curBit), .nextBit(nextBit), .lastBit(lastBit),
    .strobe(strobe), .fieldOn(fieldOn), .busy(busy), .done(done)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int CLKS_PER_US = 48,
  parameter int ONE_OFF_US  = 1000,
  parameter int ZERO_OFF_US = 300
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic fieldOn,
  input logic busy,
  input logic done
);
  localparam int ONE_GAP  = ONE_OFF_US * CLKS_PER_US;
  localparam int ZERO_GAP = ZERO_OFF_US * CLKS_PER_US;

  int offRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offRun <= 0;
    else if (busy && !fieldOn) offRun <= offRun + 1;
    else                      offRun <= 0;
  end

  a_r1_idle_field_off: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !fieldOn);

  a_r2_start_charges: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && fieldOn));

  // R3 and R4: every gap ends with one of the two legal lengths
  a_r3_gap_length: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fieldOn && offRun != 0) |-> (offRun == ONE_GAP || offRun == ZERO_GAP));

  a_r9_field_on_before_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(fieldOn));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_closes_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r11_start_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind pulse_gap_writer pgw_checker #(
  .CLKS_PER_US(CLKS_PER_US), .ONE_OFF_US(ONE_OFF_US), .ZERO_OFF_US(ZERO_OFF_US)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .fieldOn(fieldOn), .busy(busy), .done(done)
);

// File: tb/pulse_gap_writer_tb.sv
module pulse_gap_writer_tb;
  localparam int C    = 2;
  localparam int CHG  = 12;
  localparam int HLD  = 10;
  localparam int O1   = 3;
  localparam int N1   = 3;
  localparam int O0   = 1;
  localparam int N0   = 5;

  logic clk = 0, rstN = 0, start = 0;
  logic [63:0] dataWord = '0;
  logic [15:0] crcIn = '0;
  logic fieldOn, busy, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_gap_writer #(
    .CLKS_PER_US(C), .CHARGE_US(CHG), .HOLD_US(HLD),
    .ONE_OFF_US(O1), .ONE_ON_US(N1), .ZERO_OFF_US(O0), .ZERO_ON_US(N0)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dataWord(dataWord), .crcIn(crcIn),
    .fieldOn(fieldOn), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [63:0] d);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < 64; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic countRun(input logic level, output int n);
    n = 0;
    while (fieldOn === level && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // one full write, decoded from the field waveform
  task automatic doWrite(input logic [63:0] d, input logic [15:0] c, input bit poke);
    logic [111:0] got, exp;
    logic [15:0] expCrc;
    int runLen, offLen, onLen, errOne, errZero;
    string crcReq;
    expCrc = (c == 16'h0000) ? refCrc(d) : c;
    crcReq = (c == 16'h0000) ? "R8" : "R7";
    exp = {8'h03, 8'h00, expCrc, d, 8'hEB, 8'hBB};
    got = '0; errOne = 0; errZero = 0;
    @(negedge clk);
    dataWord = d; crcIn = c; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1 && fieldOn === 1'b1, "R2", "busy/field after start", {busy, fieldOn}, 2'b11);
    countRun(1'b1, runLen);
    chk(runLen == CHG * C, "R2", "charge cycles", runLen, CHG * C);
    for (int b = 0; b < 112; b++) begin
      if (poke && b == 40) begin
        start = 1; dataWord = ~d; crcIn = ~c;
        @(negedge clk);
        start = 0;
        countRun(1'b0, offLen);
        offLen = offLen + 1;
      end else begin
        countRun(1'b0, offLen);
      end
      countRun(1'b1, onLen);
      if (b == 111) onLen = onLen - HLD * C;
      got[b] = (offLen == O1 * C);
      if (got[b] && onLen != N1 * C) errOne++;
      if (!got[b] && (offLen != O0 * C || onLen != N0 * C)) errZero++;
    end
    chk(errOne == 0, "R3", "one-bit timing errors", errOne, 0);
    chk(errZero == 0, "R4", "zero-bit timing errors", errZero, 0);
    for (int k = 0; k < 14; k++)
      chk(got[8*k +: 8] == exp[8*k +: 8], (k == 10 || k == 11) ? crcReq : "R5/R6",
          $sformatf("frame byte %0d%s", k, poke ? " (R11 poke)" : ""),
          got[8*k +: 8], exp[8*k +: 8]);
    chk(busy === 1'b0 && done === 1'b1, "R10", "done with busy fall", {busy, done}, 2'b01);
    chk(fieldOn === 1'b0, "R9", "field off after hold", fieldOn, 0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", done, 0);
  endtask

  task automatic testReset();
    chk(fieldOn === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "reset outputs",
        {fieldOn, busy, done}, 0);
    repeat (20) @(negedge clk);
    chk(fieldOn === 1'b0 && busy === 1'b0, "R1", "idle without start", {fieldOn, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    doWrite(64'h0123_4567_89AB_CDEF, 16'hBEEF, 0);  // R7 verbatim
    doWrite(64'h0123_4567_89AB_CDEF, 16'h0000, 0);  // R8 computed
    doWrite(64'hFFFF_FFFF_FFFF_FFFF, 16'h0001, 0);  // R3 dense ones
    doWrite(64'h0000_0000_0000_0000, 16'h0000, 0);  // R4 dense zeros
    doWrite(64'hA5C3_0F96_1E2D_3C4B, 16'h0000, 1);  // R11 start during write
    testReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule